// File: doc/BRIEF.md
# Register-Write Descriptor Ring Master

This engine walks a circular table of 16-byte descriptors held in system memory, without help from the host. Each descriptor names a buffer in memory, and that buffer holds a stream of word pairs: an encoded register index, then a value. The engine turns every pair into one write on an internal register-write port. The index is decoded into one of two 256-entry register blocks.

The host sets the table pointer and the ring size, arms the engine through a source-control register and starts it with a write to a start register. The engine then fetches descriptors until it finds one whose command word carries the last-descriptor flag. It stops there and raises a sticky end-of-list flag. The host keeps adding descriptors behind the table pointer and starts the engine again; each new run begins where the last one stopped.

Memory requests, memory responses and register writes are valid/ready streams. A request or a write, once its valid is high, keeps its valid, address and data stable until ready is seen. The engine never has more than one memory read outstanding. It holds `mem_rsp_ready` high only while it waits for that read.

Top module: `regring_master`

## Requirements
- R1: After reset the following are all zero: `busy`, `eol_flag`, `err_cnt`, `table_ptr`, `mem_req_valid`, `mem_rsp_ready` and `rw_valid`.
- R2: Control writes are decoded by `ctl_sel`:
  - 0 is the table command: pointer in bits [31:4], ring-size code in bits [1:0].
  - 1 is source control: bit 0 is enable, bits [2:1] are the operation, and operation 3 means system-to-register.
  - 2 is start.
  - 3 is interrupt status.

  A start write has an effect only when the engine is idle, enable is 1 and the operation is 3. Any other start write changes nothing.
- R3: A descriptor is four words, fetched in order from the table pointer plus 0, 4, 8 and 12. Word 1 is the buffer byte address and word 2 is the command word. Word 0 (destination offset) and word 3 (status) are fetched but not used. Command bits [12:0] give the buffer length in bytes. The engine processes length/8 pairs (rounded down), in memory order.
- R4: An index in 0x100..0x1FF writes byte address (index & 0xFF)*4. An index below 0x100 writes byte address index*4 + 0x400. `rw_addr` is 11 bits wide.
- R5: An index of 0x200 or above is dropped without a write. It adds one to `err_cnt`, which saturates at its maximum. The rest of the buffer is still processed.
- R6: Command bit 31 marks the last descriptor. The engine stops after that descriptor; otherwise it goes on to the next descriptor.
- R7: The table pointer advances by 16 per descriptor and wraps inside an aligned window of 16 KB shifted left by the size code (16, 32, 64 or 128 KB for codes 0 to 3).
- R8: Bits [3:0] of `table_ptr` always read 0. The pointer advances as soon as the fourth word of a descriptor is fetched, so during that descriptor's data phase it points one descriptor further. A new start continues from the pointer's current value.
- R9: A table-command write while `busy` is high is ignored.
- R10: `busy` rises in the cycle after an accepted start write. It stays high until the last register write of the last descriptor has been accepted. `eol_flag` is already high in the first cycle in which `busy` is low again.
- R11: `eol_flag` is sticky. An interrupt-status write with bit 0 set clears it; a write with bit 0 clear leaves it unchanged.
- R12: Once `mem_req_valid` or `rw_valid` is high, it stays high with stable address and data until the matching ready is seen.
- R13: A length field above 4096 bytes is treated as 4096 bytes, which is 512 pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_sel | input | 2 | Control register select |
| ctl_wdata | input | 32 | Control write data |
| table_ptr | output | 32 | Next descriptor address |
| busy | output | 1 | Engine running |
| eol_flag | output | 1 | Sticky end-of-list status |
| err_cnt | output | 8 | Dropped-pair counter |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waiting for read data |
| mem_rsp_data | input | 32 | Read data |
| rw_valid | output | 1 | Register write valid |
| rw_ready | input | 1 | Register write accepted |
| rw_addr | output | 11 | Register byte address |
| rw_data | output | 32 | Register write value |

## Verification
The assertions check the following on every cycle:
- request and write stability under back-pressure;
- alignment of the table pointer and of register addresses;
- silence of every stream while the engine is idle;
- monotonic error counting;
- the end-of-list flag being set when `busy` falls, and its stickiness.

Only the bench scenarios can show that the right registers receive the right values in the right order. The same holds for:
- the wrap point for each of the four ring sizes;
- the stop at the last-descriptor flag, with a live descriptor sitting behind it;
- resuming from the stopped pointer;
- start writes that must be ignored;
- length capping.

// File: rtl/regring_pkg.sv
package regring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DRSP, ST_XREQ, ST_XRSP, ST_WR, ST_NEXT
  } walk_st_t;

  localparam logic [1:0] SEL_TABLE = 2'd0;
  localparam logic [1:0] SEL_SRC   = 2'd1;
  localparam logic [1:0] SEL_GO    = 2'd2;
  localparam logic [1:0] SEL_IRQ   = 2'd3;

  localparam logic [1:0] OP_SYS2REG = 2'd3;
endpackage

// File: rtl/regring_idx_decode.sv
module regring_idx_decode #(
  parameter int DW   = 32,
  parameter int RA_W = 11
) (
  input  logic [DW-1:0]   idx,
  output logic [RA_W-1:0] addr,
  output logic            bad
);
  localparam int BLK_LOG2 = RA_W - 3;

  // bit BLK_LOG2 picks the block: set -> lower block, clear -> upper block
  assign addr = {~idx[BLK_LOG2], idx[BLK_LOG2-1:0], 2'b00};
  assign bad  = |idx[DW-1:BLK_LOG2+1];
endmodule

// File: rtl/regring_ring_ptr.sv
module regring_ring_ptr #(
  parameter int AW            = 32,
  parameter int MIN_RING_LOG2 = 14,
  parameter int CODE_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     load_val,
  input  logic [CODE_W-1:0] load_code,
  input  logic              adv,
  output logic [AW-1:0]     ptr
);
  localparam logic [AW-1:0] MIN_BYTES = AW'(1) << MIN_RING_LOG2;
  localparam logic [AW-1:0] DESC_BYTES = AW'(16);

  logic [CODE_W-1:0] code_q;
  logic [AW-1:0]     ptr_q;
  logic [AW-1:0]     mask;
  logic [AW-1:0]     step;

  assign mask = (MIN_BYTES << code_q) - AW'(1);
  assign step = ptr_q + DESC_BYTES;
  assign ptr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      code_q <= '0;
    end else if (load) begin
      ptr_q  <= {load_val[AW-1:4], 4'b0000};
      code_q <= load_code;
    end else if (adv) begin
      ptr_q  <= (ptr_q & ~mask) | (step & mask);
    end
  end
endmodule

// File: rtl/regring_walker.sv
module regring_walker
  import regring_pkg::*;
#(
  parameter int AW             = 32,
  parameter int DW             = 32,
  parameter int RA_W           = 11,
  parameter int MAX_XFER_BYTES = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   ptr,
  output logic            adv,
  output logic            eol_set,
  output logic            err_inc,
  output logic            busy,
  output logic [DW-1:0]   pair_idx,
  input  logic [RA_W-1:0] dec_addr,
  input  logic            dec_bad,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            rw_valid,
  input  logic            rw_ready,
  output logic [RA_W-1:0] rw_addr,
  output logic [DW-1:0]   rw_data
);
  localparam int LEN_W = $clog2(MAX_XFER_BYTES) + 1;
  localparam int WC_W  = LEN_W - 2;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_XFER_BYTES);

  walk_st_t         st;
  logic [1:0]       k;
  logic [AW-1:0]    saddr_q;
  logic [DW-1:0]    cmd_q;
  logic [DW-1:0]    idx_q;
  logic [DW-1:0]    val_q;
  logic [WC_W-1:0]  widx;
  logic [WC_W-1:0]  wtot;
  logic [LEN_W-1:0] len_raw;
  logic [LEN_W-1:0] len_cap;
  logic [WC_W-1:0]  words;
  logic             rsp_fire;

  assign len_raw  = cmd_q[LEN_W-1:0];
  assign len_cap  = (len_raw > LEN_MAX) ? LEN_MAX : len_raw;
  assign words    = {len_cap[LEN_W-1:3], 1'b0};
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;

  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = (st == ST_DREQ) || (st == ST_XREQ);
  assign mem_req_addr  = (st == ST_DREQ) ? ptr + AW'({k, 2'b00})
                                         : saddr_q + AW'({widx, 2'b00});
  assign mem_rsp_ready = (st == ST_DRSP) || (st == ST_XRSP);
  assign rw_valid      = (st == ST_WR);
  assign rw_addr       = dec_addr;
  assign rw_data       = val_q;
  assign pair_idx      = idx_q;
  assign adv           = (st == ST_DRSP) && rsp_fire && (k == 2'd3);
  assign eol_set       = (st == ST_NEXT) && cmd_q[DW-1];
  assign err_inc       = (st == ST_XRSP) && rsp_fire && widx[0] && dec_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      k       <= '0;
      saddr_q <= '0;
      cmd_q   <= '0;
      idx_q   <= '0;
      val_q   <= '0;
      widx    <= '0;
      wtot    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          k  <= '0;
          st <= ST_DREQ;
        end
        ST_DREQ: if (mem_req_ready) st <= ST_DRSP;
        ST_DRSP: if (rsp_fire) begin
          if (k == 2'd1) saddr_q <= mem_rsp_data;
          if (k == 2'd2) cmd_q   <= mem_rsp_data;
          if (k == 2'd3) begin
            widx <= '0;
            wtot <= words;
            st   <= (words == '0) ? ST_NEXT : ST_XREQ;
          end else begin
            k  <= k + 2'd1;
            st <= ST_DREQ;
          end
        end
        ST_XREQ: if (mem_req_ready) st <= ST_XRSP;
        ST_XRSP: if (rsp_fire) begin
          widx <= widx + WC_W'(1);
          if (!widx[0]) begin
            idx_q <= mem_rsp_data;
            st    <= ST_XREQ;
          end else begin
            val_q <= mem_rsp_data;
            if (dec_bad) st <= (widx + WC_W'(1) == wtot) ? ST_NEXT : ST_XREQ;
            else         st <= ST_WR;
          end
        end
        ST_WR: if (rw_ready) st <= (widx == wtot) ? ST_NEXT : ST_XREQ;
        ST_NEXT: begin
          if (cmd_q[DW-1]) st <= ST_IDLE;
          else begin
            k  <= '0;
            st <= ST_DREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regring_master.sv
module regring_master
  import regring_pkg::*;
#(
  parameter int AW             = 32,
  parameter int DW             = 32,
  parameter int RA_W           = 11,
  parameter int ERR_W          = 8,
  parameter int MIN_RING_LOG2  = 14,
  parameter int MAX_XFER_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_sel,
  input  logic [DW-1:0]    ctl_wdata,
  output logic [AW-1:0]    table_ptr,
  output logic             busy,
  output logic             eol_flag,
  output logic [ERR_W-1:0] err_cnt,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             rw_valid,
  input  logic             rw_ready,
  output logic [RA_W-1:0]  rw_addr,
  output logic [DW-1:0]    rw_data
);
  logic          src_en;
  logic [1:0]    src_op;
  logic          start;
  logic          tbl_load;
  logic          adv;
  logic          eol_set;
  logic          err_inc;
  logic [DW-1:0] pair_idx;
  logic [RA_W-1:0] dec_addr;
  logic          dec_bad;

  assign tbl_load = ctl_wr && (ctl_sel == SEL_TABLE) && !busy;
  assign start    = ctl_wr && (ctl_sel == SEL_GO) && src_en
                    && (src_op == OP_SYS2REG) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_en   <= 1'b0;
      src_op   <= '0;
      eol_flag <= 1'b0;
      err_cnt  <= '0;
    end else begin
      if (ctl_wr && ctl_sel == SEL_SRC) begin
        src_en <= ctl_wdata[0];
        src_op <= ctl_wdata[2:1];
      end
      if (eol_set)
        eol_flag <= 1'b1;
      else if (ctl_wr && ctl_sel == SEL_IRQ && ctl_wdata[0])
        eol_flag <= 1'b0;
      if (err_inc && err_cnt != '1)
        err_cnt <= err_cnt + ERR_W'(1);
    end
  end

  regring_ring_ptr #(
    .AW(AW), .MIN_RING_LOG2(MIN_RING_LOG2), .CODE_W(2)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(tbl_load),
    .load_val(ctl_wdata[AW-1:0]), .load_code(ctl_wdata[1:0]),
    .adv(adv), .ptr(table_ptr)
  );

  regring_idx_decode #(.DW(DW), .RA_W(RA_W)) u_dec (
    .idx(pair_idx), .addr(dec_addr), .bad(dec_bad)
  );

  regring_walker #(
    .AW(AW), .DW(DW), .RA_W(RA_W), .MAX_XFER_BYTES(MAX_XFER_BYTES)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr(table_ptr),
    .adv(adv), .eol_set(eol_set), .err_inc(err_inc), .busy(busy),
    .pair_idx(pair_idx), .dec_addr(dec_addr), .dec_bad(dec_bad),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rw_valid(rw_valid), .rw_ready(rw_ready), .rw_addr(rw_addr),
    .rw_data(rw_data)
  );
endmodule

// File: rtl/regring_master_chk.sv
module regring_master_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int RA_W  = 11,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [1:0]       ctl_sel,
  input logic [DW-1:0]    ctl_wdata,
  input logic [AW-1:0]    table_ptr,
  input logic             busy,
  input logic             eol_flag,
  input logic [ERR_W-1:0] err_cnt,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_ready,
  input logic             rw_valid,
  input logic             rw_ready,
  input logic [RA_W-1:0]  rw_addr,
  input logic [DW-1:0]    rw_data
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid && !rw_ready |=> rw_valid && $stable(rw_addr) && $stable(rw_data));

  // R8
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_ptr[3:0] == 4'b0000);

  // R4
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |-> rw_addr[1:0] == 2'b00);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready && !rw_valid);

  // R10
  eol_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eol_flag);

  // R11
  eol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_flag && !(ctl_wr && ctl_sel == 2'd3 && ctl_wdata[0]) |=> eol_flag);

  // R5
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> err_cnt >= $past(err_cnt));
endmodule

bind regring_master regring_master_chk #(
  .AW(AW), .DW(DW), .RA_W(RA_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
  .ctl_wdata(ctl_wdata), .table_ptr(table_ptr), .busy(busy),
  .eol_flag(eol_flag), .err_cnt(err_cnt), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_ready(mem_rsp_ready), .rw_valid(rw_valid), .rw_ready(rw_ready),
  .rw_addr(rw_addr), .rw_data(rw_data)
);

// File: tb/regring_master_test.sv
module regring_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [1:0]  ctl_sel = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] table_ptr;
  logic        busy, eol_flag;
  logic [7:0]  err_cnt;
  logic        mem_req_valid, mem_rsp_ready, rw_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, rw_data;
  logic [31:0] mem_rsp_data = '0;
  logic        rw_ready = 1'b0;
  logic [10:0] rw_addr;

  regring_master uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .table_ptr(table_ptr), .busy(busy),
    .eol_flag(eol_flag), .err_cnt(err_cnt), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .rw_valid(rw_valid), .rw_ready(rw_ready),
    .rw_addr(rw_addr), .rw_data(rw_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R3";
  logic [31:0] mem [int unsigned];
  logic [42:0] exp_q [$];
  int n_writes = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory and register-port model, all decisions at the falling edge
  logic        last_req_fire = 1'b0, last_rsp_fire = 1'b0, pend = 1'b0;
  logic [31:0] last_addr = '0, paddr = '0;
  initial forever begin
    @(negedge clk);
    cyc++;
    if (last_rsp_fire) mem_rsp_valid = 1'b0;
    if (last_req_fire) begin pend = 1'b1; paddr = last_addr; end
    if (!mem_rsp_valid && pend && cyc[0]) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rd(paddr);
      pend = 1'b0;
    end
    mem_req_ready = (cyc % 3) != 0;
    rw_ready      = (cyc % 4) != 1;
    last_req_fire = mem_req_valid && mem_req_ready;
    last_addr     = mem_req_addr;
    last_rsp_fire = mem_rsp_valid && mem_rsp_ready;
    if (rw_valid && rw_ready) begin
      n_writes++;
      if (exp_q.size() == 0)
        chk(1'b0, cur_req, {rw_addr, rw_data}, 0);
      else begin
        logic [42:0] e;
        e = exp_q.pop_front();
        chk({rw_addr, rw_data} == e, cur_req, {rw_addr, rw_data}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic ctl(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // expected register byte address for an index (R4)
  function automatic logic [10:0] exp_addr(input logic [31:0] idx);
    if (idx >= 32'h100) return 11'((idx & 32'hFF) * 4);
    return 11'(idx * 4 + 32'h400);
  endfunction

  // place a descriptor and its buffer; queue the expected writes
  task automatic put_desc(input logic [31:0] at, input logic [31:0] buf_a,
                          input int lenb, input bit eol, input int bad_at,
                          input int seed, input bit expect_it);
    int np;
    np = ((lenb > 4096) ? 4096 : lenb) / 8;
    mem[at]      = 32'hDEAD0000;
    mem[at + 4]  = buf_a;
    mem[at + 8]  = {eol, 18'h0, 13'(lenb)};
    mem[at + 12] = 32'h0;
    for (int j = 0; j < np; j++) begin
      logic [31:0] idx, val;
      if (j == bad_at) idx = 32'h200 + j;
      else if (j % 2 == 0) idx = 32'((seed + j) & 8'hFF);
      else idx = 32'h100 | 32'((seed * 3 + j) & 8'hFF);
      val = (seed << 16) + j;
      mem[buf_a + 8*j]     = idx;
      mem[buf_a + 8*j + 4] = val;
      if (expect_it && j != bad_at) exp_q.push_back({exp_addr(idx), val});
    end
  endtask

  task automatic run_wait(input string req);
    int lim;
    lim = 0;
    ctl(2'd2, 32'h0);
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    chk(!busy, req, busy, 0);
    // R10: busy low only after every expected write was accepted
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    chk(eol_flag, "R10", eol_flag, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !eol_flag && err_cnt == 0 && table_ptr == 0, "R1",
        {busy, eol_flag, err_cnt, table_ptr}, 0);
    chk(!mem_req_valid && !mem_rsp_ready && !rw_valid, "R1",
        {mem_req_valid, mem_rsp_ready, rw_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start ignored when not armed
    ctl(2'd0, 32'h0002_0000);
    put_desc(32'h0002_0000, 32'h0008_0000, 16, 1, -1, 1, 0);
    ctl(2'd1, 32'h5);           // op 2, enabled
    ctl(2'd2, 32'h0);
    repeat (6) @(negedge clk);
    chk(!busy && n_writes == 0 && table_ptr == 32'h0002_0000, "R2", busy, 0);
    ctl(2'd1, 32'h6);           // op 3, disabled
    ctl(2'd2, 32'h0);
    repeat (6) @(negedge clk);
    chk(!busy && n_writes == 0, "R2", n_writes, 0);

    // R3 R4 R9: single descriptor, table write while busy ignored
    cur_req = "R4";
    ctl(2'd1, 32'h7);
    put_desc(32'h0002_0000, 32'h0008_0000, 40, 1, -1, 1, 1);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = 2'd2;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(busy, "R10", busy, 1);
    ctl(2'd0, 32'h0004_0000);
    run_wait_tail("R3");
    chk(table_ptr == 32'h0002_0010, "R9", table_ptr, 32'h0002_0010);

    // R11
    ctl(2'd3, 32'h0);
    chk(eol_flag, "R11", eol_flag, 1);
    ctl(2'd3, 32'h1);
    chk(!eol_flag, "R11", eol_flag, 0);

    // R6: chain with an empty descriptor; entry after the last must not run
    cur_req = "R6";
    ctl(2'd0, 32'h0003_0000);
    put_desc(32'h0003_0000, 32'h0009_0000, 16, 0, -1, 2, 1);
    put_desc(32'h0003_0010, 32'h0009_1000, 0, 0, -1, 3, 1);
    put_desc(32'h0003_0020, 32'h0009_2000, 24, 1, -1, 4, 1);
    put_desc(32'h0003_0030, 32'h0009_3000, 16, 1, -1, 5, 0);
    run_wait("R6");
    chk(table_ptr == 32'h0003_0030, "R6", table_ptr, 32'h0003_0030);

    // R8: resume from where the engine stopped
    cur_req = "R8";
    put_desc(32'h0003_0030, 32'h0009_3000, 16, 1, -1, 5, 1);
    run_wait("R8");
    chk(table_ptr == 32'h0003_0040, "R8", table_ptr, 32'h0003_0040);

    // R5: out-of-range index dropped and counted
    cur_req = "R5";
    ctl(2'd0, 32'h0005_0000);
    put_desc(32'h0005_0000, 32'h000A_0000, 32, 1, 2, 6, 1);
    run_wait("R5");
    chk(err_cnt == 8'd1, "R5", err_cnt, 1);

    // R7: wrap for every ring size
    for (int code = 0; code < 4; code++) begin
      logic [31:0] w, sz;
      cur_req = "R7";
      w  = 32'h0010_0000 + 32'(code) * 32'h0004_0000;
      sz = 32'h4000 << code;
      ctl(2'd0, w + sz - 16 + 32'(code));
      chk(table_ptr == w + sz - 16, "R8", table_ptr, w + sz - 16);
      put_desc(w + sz - 16, 32'h000B_0000, 8 * (code + 1), 0, -1, 10 + code, 1);
      put_desc(w, 32'h000B_8000, 16, 1, -1, 20 + code, 1);
      run_wait("R7");
      chk(table_ptr == w + 16, "R7", table_ptr, w + 16);
    end

    // R13: oversize length capped to 512 pairs
    cur_req = "R13";
    ctl(2'd0, 32'h0006_0000);
    put_desc(32'h0006_0000, 32'h000C_0000, 32'h1FF8, 1, -1, 7, 1);
    n_writes = 0;
    run_wait("R13");
    chk(n_writes == 512, "R13", n_writes, 512);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // wait for completion after a start already issued
  task automatic run_wait_tail(input string req);
    int lim;
    lim = 0;
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    chk(!busy, req, busy, 0);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    chk(eol_flag, "R10", eol_flag, 1);
    exp_q.delete();
  endtask
endmodule